// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder/Subtractor

This block is a purely combinational two's-complement adder/subtractor of parameterised width. A single mode input chooses between sum and difference. In subtract mode every bit of the second operand is inverted and a one is injected as the incoming carry, so the same carry network serves both operations.

Each bit forms a generate term (both operand bits set) and a propagate term (operand bits differ). The operand is cut into four-bit groups. Inside a group, a two-level lookahead generator forms all four carries at once from those terms and the group's incoming carry. The group carry-outs chain from the least significant group to the most significant one.

The block returns the truncated result, the final carry and a signed overflow flag. The overflow flag is the mismatch between the carry entering the top bit and the carry leaving it. It has no clock, no state and no registers. The "state" naming of the house style reduces to a single implicit condition: the mode value (ADD when 0, SUB when 1), with no transitions other than the input changing.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_i` = 0, `result_o` equals (`a_i` + `b_i`) modulo 2^WIDTH.
- R2: With `sub_i` = 0, `carry_o` equals bit WIDTH of the unsigned sum `a_i` + `b_i`.
- R3: With `sub_i` = 1, `result_o` equals (`a_i` − `b_i`) modulo 2^WIDTH.
- R4: With `sub_i` = 1, `carry_o` is 1 exactly when `a_i` ≥ `b_i` as unsigned numbers, meaning no borrow occurred.
- R5: `ovf_o` is 1 exactly when the signed result does not fit in WIDTH bits. In add mode this means both operands have equal sign bits (bit WIDTH−1) and the result's sign bit differs from them. In subtract mode it means the operands' sign bits differ and the result's sign bit differs from that of `a_i`.
- R6: A carry born in bit 0 reaches every group boundary. At WIDTH 16, 0xFFFF + 0x0001 gives result 0x0000, carry 1 and overflow 0.
- R7: Subtracting zero returns `a_i` unchanged with `carry_o` = 1 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts |
| result_o | output | WIDTH | Sum or difference, truncated to WIDTH bits |
| carry_o | output | 1 | Carry out of the most significant group |
| ovf_o | output | 1 | Signed two's-complement overflow |

## Verification
The final carry and the signed overflow can both be raised by the same operand pair. This happens, for example, when two most-negative values are added, or when a negative value minus a positive one wraps. The bench forces such pairs and judges both flags independently against unsigned and signed reference arithmetic. It also drives a carry that must cross every group boundary in the same evaluation in which the mode changes. The four-bit width is covered exhaustively in both modes, so every coincidence of carry and overflow at that width is reached.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int GRP_W = 4;

    typedef struct packed {
        logic g;
        logic p;
    } pg_t;
endpackage

// File: rtl/cla_operand_cond.sv
module cla_operand_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_raw,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] b_eff,
    output logic             c_inject
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_eff[i] = b_raw[i] ^ sub_mode;
    end
    assign c_inject = sub_mode;

    always_comb begin
        // R3: subtract mode must present the ones' complement of B
        p_inv_r3: assert (sub_mode ? (b_eff == ~b_raw) : (b_eff == b_raw));
    end
endmodule

// File: rtl/cla_pg_row.sv
module cla_pg_row
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    output pg_t  [WIDTH-1:0] pg
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg[i].g = op_x[i] & op_y[i];
        assign pg[i].p = op_x[i] ^ op_y[i];
    end
endmodule

// File: rtl/cla_group4.sv
module cla_group4
    import cla_pkg::*;
(
    input  pg_t  [GRP_W-1:0] pg,
    input  logic             cin,
    output logic [GRP_W-1:0] sum,
    output logic             c_top_in,
    output logic             cout
);
    logic [GRP_W:0] c;

    assign c[0] = cin;
    assign c[1] = pg[0].g | (pg[0].p & cin);
    assign c[2] = pg[1].g | (pg[1].p & pg[0].g) | (pg[1].p & pg[0].p & cin);
    assign c[3] = pg[2].g | (pg[2].p & pg[1].g) | (pg[2].p & pg[1].p & pg[0].g)
                | (pg[2].p & pg[1].p & pg[0].p & cin);
    assign c[4] = pg[3].g | (pg[3].p & pg[2].g) | (pg[3].p & pg[2].p & pg[1].g)
                | (pg[3].p & pg[2].p & pg[1].p & pg[0].g)
                | (pg[3].p & pg[2].p & pg[1].p & pg[0].p & cin);

    for (genvar i = 0; i < GRP_W; i++) begin : g_sum
        assign sum[i] = pg[i].p ^ c[i];
    end

    assign c_top_in = c[GRP_W-1];
    assign cout     = c[GRP_W];

    logic [GRP_W+1:0] weight_sum;
    always_comb begin
        weight_sum = {{(GRP_W+1){1'b0}}, cin};
        for (int i = 0; i < GRP_W; i++) begin
            weight_sum = weight_sum + ((GRP_W+2)'(2 * pg[i].g + pg[i].p) << i);
        end
        // R2: group carry and sum equal the weighted generate/propagate total
        p_grp_total_r2: assert ({cout, sum} == weight_sum[GRP_W:0]);
    end
endmodule

// File: rtl/cla_addsub.sv
module cla_addsub
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int NGRP = WIDTH / GRP_W;

    logic [WIDTH-1:0] b_eff;
    logic             c_inj;
    pg_t  [WIDTH-1:0] pg;
    logic [NGRP:0]    gc;
    logic [NGRP-1:0]  top_in;

    cla_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_raw    (b_i),
        .sub_mode (sub_i),
        .b_eff    (b_eff),
        .c_inject (c_inj)
    );

    cla_pg_row #(.WIDTH(WIDTH)) u_pg (
        .op_x (a_i),
        .op_y (b_eff),
        .pg   (pg)
    );

    assign gc[0] = c_inj;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_group4 u_grp (
            .pg       (pg[k*GRP_W +: GRP_W]),
            .cin      (gc[k]),
            .sum      (result_o[k*GRP_W +: GRP_W]),
            .c_top_in (top_in[k]),
            .cout     (gc[k+1])
        );
    end

    assign carry_o = gc[NGRP];
    assign ovf_o   = top_in[NGRP-1] ^ gc[NGRP];

    logic [WIDTH-1:0] ref_sum;
    logic [WIDTH-1:0] ref_dif;
    logic             sa, sb, sr;
    always_comb begin
        ref_sum = a_i + b_i;
        ref_dif = a_i - b_i;
        sa = a_i[WIDTH-1];
        sb = b_i[WIDTH-1];
        sr = result_o[WIDTH-1];
        if (!sub_i) begin
            p_add_r1: assert (result_o == ref_sum);
            p_ovf_add_r5: assert (ovf_o == ((sa == sb) && (sr != sa)));
        end else begin
            p_sub_r3: assert (result_o == ref_dif);
            p_no_borrow_r4: assert (carry_o == (a_i >= b_i));
            p_ovf_sub_r5: assert (ovf_o == ((sa != sb) && (sr != sa)));
        end
    end
endmodule

// File: tb/cla_addsub_tb.sv
module cla_addsub_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;

    logic [15:0] a16, b16, r16;
    logic        s16, c16, v16;
    logic [3:0]  a4, b4, r4;
    logic        s4, c4, v4;

    cla_addsub #(.WIDTH(16)) u_dut (
        .a_i(a16), .b_i(b16), .sub_i(s16),
        .result_o(r16), .carry_o(c16), .ovf_o(v16)
    );

    cla_addsub #(.WIDTH(4)) u_dut4 (
        .a_i(a4), .b_i(b4), .sub_i(s4),
        .result_o(r4), .carry_o(c4), .ovf_o(v4)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic s);
        logic [16:0] full;
        logic [15:0] er;
        logic        ec, ev;
        @(posedge clk);
        #1;
        a16 = a; b16 = b; s16 = s;
        @(negedge clk);
        if (!s) begin
            full = {1'b0, a} + {1'b0, b};
            er = full[15:0];
            ec = full[16];
            ev = (a[15] == b[15]) && (er[15] != a[15]);
            chk("R1 add result", 32'(r16), 32'(er));
            chk("R2 add carry", 32'(c16), 32'(ec));
        end else begin
            er = a - b;
            ec = (a >= b);
            ev = (a[15] != b[15]) && (er[15] != a[15]);
            chk("R3 sub result", 32'(r16), 32'(er));
            chk("R4 sub carry", 32'(c16), 32'(ec));
        end
        chk("R5 overflow", 32'(v16), 32'(ev));
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic s);
        logic [4:0] full;
        logic [3:0] er;
        logic       ec, ev;
        @(posedge clk);
        #1;
        a4 = a; b4 = b; s4 = s;
        @(negedge clk);
        if (!s) begin
            full = {1'b0, a} + {1'b0, b};
            er = full[3:0];
            ec = full[4];
            ev = (a[3] == b[3]) && (er[3] != a[3]);
            chk("R1 add result w4", 32'(r4), 32'(er));
            chk("R2 add carry w4", 32'(c4), 32'(ec));
        end else begin
            er = a - b;
            ec = (a >= b);
            ev = (a[3] != b[3]) && (er[3] != a[3]);
            chk("R3 sub result w4", 32'(r4), 32'(er));
            chk("R4 sub carry w4", 32'(c4), 32'(ec));
        end
        chk("R5 overflow w4", 32'(v4), 32'(ev));
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk("R1 idle result", 32'(r16), 32'h0);
        chk("R2 idle carry", 32'(c16), 32'h0);
        chk("R5 idle overflow", 32'(v16), 32'h0);
    endtask

    task automatic t_exhaustive4;
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    run4(4'(x), 4'(y), m[0]);
    endtask

    task automatic t_chain_r6;
        run16(16'hFFFF, 16'h0001, 1'b0);
        chk("R6 chain result", 32'(r16), 32'h0000);
        chk("R6 chain carry", 32'(c16), 32'h1);
        chk("R6 chain overflow", 32'(v16), 32'h0);
        run16(16'h0FFF, 16'h0001, 1'b0);
        chk("R6 partial chain", 32'(r16), 32'h1000);
        run16(16'h0000, 16'h0001, 1'b1);
        chk("R6 borrow chain", 32'(r16), 32'hFFFF);
        chk("R6 borrow carry", 32'(c16), 32'h0);
    endtask

    task automatic t_sub_zero_r7;
        run16(16'hA5C3, 16'h0000, 1'b1);
        chk("R7 sub zero result", 32'(r16), 32'hA5C3);
        chk("R7 sub zero carry", 32'(c16), 32'h1);
        chk("R7 sub zero overflow", 32'(v16), 32'h0);
    endtask

    task automatic t_overflow_corners;
        run16(16'h7FFF, 16'h0001, 1'b0);
        chk("R5 pos wrap", 32'(v16), 32'h1);
        run16(16'h8000, 16'h8000, 1'b0);
        chk("R5 neg wrap ovf", 32'(v16), 32'h1);
        chk("R2 neg wrap carry", 32'(c16), 32'h1);
        run16(16'h8000, 16'h0001, 1'b1);
        chk("R5 sub wrap ovf", 32'(v16), 32'h1);
        chk("R4 sub wrap carry", 32'(c16), 32'h1);
        run16(16'h0000, 16'h8000, 1'b1);
        chk("R5 sub min ovf", 32'(v16), 32'h1);
        run16(16'h1234, 16'h1234, 1'b1);
        chk("R4 equal carry", 32'(c16), 32'h1);
    endtask

    task automatic t_random16;
        for (int i = 0; i < 3000; i++)
            run16(16'($urandom), 16'($urandom), 1'($urandom));
    endtask

    initial begin
        a16 = '0; b16 = '0; s16 = 1'b0;
        a4 = '0; b4 = '0; s4 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_exhaustive4();
        t_chain_r6();
        t_sub_zero_r7();
        t_overflow_corners();
        t_random16();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule